// File: doc/BRIEF.md
# Codec Serial Port with On-Demand Control Timeslot

This block is the clock-master serial port of a telephony codec. From the chip clock it derives a serial bit clock and a frame sync. A frame lasts 256 bit periods and runs at the sample rate. Every frame carries a primary timeslot. In that slot the attached signal processor shifts a 16-bit playback word in on `sdi`, and the block shifts a 16-bit capture word out on `sdo`. Both directions are MSB first.

Control traffic travels in a second 16-bit timeslot, 128 bit periods after the primary sync, and only in frames that asked for it. The request comes from one of two places, chosen by a mode bit in the register file. In the narrow mode (the reset state) it is the LSB of the playback word. In the wide mode it is the hardware flag input `ctl_req`. Each control slot reads or writes one 8-bit register.

On the chip side, audio moves over two valid/ready streams. The capture stream (`cap_*`) has a one-word holding register. `cap_ready` is high only while that register is empty, and the producer must hold `cap_valid` and `cap_data` until the handshake. The playback stream (`play_*`) presents each received word until `play_ready` is seen high. A newer word replaces one that has not been taken, so a slow consumer loses words and the port does not stall.

Top module: `codec_sport`

## Requirements
- R1: `sclk` is the master clock divided by CLK_DIV (an even number, at least 2). It is high for CLK_DIV/2 clock cycles and then low for CLK_DIV/2 cycles. A frame is 256 bit periods, numbered 0 to 255, with the primary slot in periods 0 to 15.
- R2: `fsync` is high for exactly one bit period. It is high in period 255 of every frame, just before primary bit 15. It changes only when `sclk` rises.
- R3: `sdo` changes only when `sclk` rises, and `sdi` is sampled when `sclk` falls. Both carry MSB first. In periods 0 to 15, `sdo` carries the capture word loaded for that frame. Outside an active slot, `sdo` is 0 and `sdi` is ignored.
- R4: After reset, `cap_ready` is 1. An accepted capture word drops `cap_ready` to 0 until the word is loaded at the start of the next primary slot. If no word is held at that point, the primary slot sends 0x0000.
- R5: Each primary slot raises `play_valid` with the received word. `play_valid` stays high until a cycle in which `play_ready` is also high. A newer word overwrites one that has not been taken.
- R6: In narrow mode (register 1 bit 0 = 0, the reset state), received bit 0 = 1 requests a control slot. `play_data` is then bits 15 to 1 with bit 0 forced to 0, and `ctl_req` has no effect.
- R7: In wide mode (register 1 bit 0 = 1), `play_data` is all 16 received bits and bit 0 requests nothing. `ctl_req` is sampled on the `sclk` fall of period 15, and a 1 there requests a control slot.
- R8: A control slot exists only when the request was made in the same frame's primary slot. It adds an `fsync` pulse in period 127 and occupies periods 128 to 143. In frames without one, `sdo` is 0 in those periods and `sdi` there changes nothing.
- R9: The control word is laid out as follows. Bit 15 = 1 means read and bit 15 = 0 means write. Bits 12:8 hold the register address and bits 7:0 hold the data. Bits 14:13 are ignored.
- R10: A write stores bits 7:0 into the addressed register if the address is below REG_COUNT. Other addresses change nothing. At most one register changes per control slot, and all registers reset to 0.
- R11: During a read, `sdo` sends 0 for control bits 15:8 and the register value for bits 7:0. Addresses at or above REG_COUNT read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync pulse, one bit period wide |
| sdo | output | 1 | Serial data to the signal processor |
| sdi | input | 1 | Serial data from the signal processor |
| ctl_req | input | 1 | Hardware control-slot request flag (wide mode) |
| cap_data | input | 16 | Capture word to transmit |
| cap_valid | input | 1 | Capture word offered |
| cap_ready | output | 1 | Capture holding register empty |
| play_data | output | 16 | Received playback word |
| play_valid | output | 1 | Playback word present |
| play_ready | input | 1 | Consumer takes playback word |

## Verification
The hardest case to reach is a change of request source that the block makes to itself. A control-slot write to register 1 switches the block into wide mode, and the change takes effect from the next frame's primary slot. The bench gets there through the serial interface alone. It first fills and reads back all 32 addresses in narrow mode, then writes the mode bit, and then checks that an odd playback word no longer opens a slot while `ctl_req` does. It also drives write words into the control slot of frames that made no request, and later reads those registers to show they did not change.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int FRAME_BITS = 256;
  localparam int SEC_START  = 128;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int MODE_REG   = 1;
  localparam int MODE_BIT   = 0;
endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          sclk,
  output logic                          rise_tick,
  output logic                          fall_tick,
  output logic [$clog2(FRAME_BITS)-1:0] bit_cnt,
  output logic [$clog2(FRAME_BITS)-1:0] next_bit
);
  localparam int CW   = $clog2(CLK_DIV);
  localparam int BW   = $clog2(FRAME_BITS);
  localparam int HALF = CLK_DIV / 2;

  logic [CW-1:0] div_q;

  assign rise_tick = (div_q == CW'(CLK_DIV - 1));
  assign fall_tick = (div_q == CW'(HALF - 1));
  assign next_bit  = (bit_cnt == BW'(FRAME_BITS - 1)) ? '0 : bit_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      sclk    <= 1'b0;
      bit_cnt <= BW'(FRAME_BITS - 2);
    end else begin
      div_q <= rise_tick ? '0 : div_q + 1'b1;
      if (rise_tick) begin
        sclk    <= 1'b1;
        bit_cnt <= next_bit;
      end else if (fall_tick) begin
        sclk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sport_regfile.sv
module sport_regfile #(
  parameter int REG_COUNT = 8,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int MODE_REG  = 1,
  parameter int MODE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              mode_wide
);
  localparam int IW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [DATA_W-1:0] regs [REG_COUNT];

  for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_q <= '0;
      else if (wr_en && int'(wr_addr) == gi)
        r_q <= wr_data;
    end
    assign regs[gi] = r_q;
  end

  assign rd_data   = (int'(rd_addr) < REG_COUNT) ? regs[rd_addr[IW-1:0]] : '0;
  assign mode_wide = regs[MODE_REG][MODE_BIT];
endmodule

// File: rtl/codec_sport.sv
module codec_sport #(
  parameter int CLK_DIV   = 4,
  parameter int REG_COUNT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        sclk,
  output logic        fsync,
  output logic        sdo,
  input  logic        sdi,
  input  logic        ctl_req,
  input  logic [15:0] cap_data,
  input  logic        cap_valid,
  output logic        cap_ready,
  output logic [15:0] play_data,
  output logic        play_valid,
  input  logic        play_ready
);
  import sport_pkg::*;

  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] P_LAST  = BW'(WORD_W - 1);
  localparam logic [BW-1:0] S_FIRST = BW'(SEC_START);
  localparam logic [BW-1:0] S_LAST  = BW'(SEC_START + WORD_W - 1);
  localparam logic [BW-1:0] S_RD    = BW'(SEC_START + WORD_W - DATA_W);
  localparam logic [BW-1:0] F_LAST  = BW'(FRAME_BITS - 1);
  localparam int RW_POS = WORD_W - DATA_W - 1;

  logic          rise_tick, fall_tick;
  logic [BW-1:0] bit_cnt, next_bit;

  sport_clkgen #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise_tick(rise_tick),
    .fall_tick(fall_tick), .bit_cnt(bit_cnt), .next_bit(next_bit)
  );

  logic [WORD_W-2:0] rx_q;
  logic [WORD_W-1:0] rx_word, tx_q, cap_q, prim_load, rd_load, play_q;
  logic              sec_pend, sec_act, cap_full, play_v_q, sdo_q, fsync_q;
  logic              mode_wide, in_prim, in_sec, prim_done, sec_done, req;
  logic              n_in_prim, n_in_sec, nsec_on, wr_en, cap_take;
  logic [DATA_W-1:0] rd_data;

  // Current and next bit-period classification
  assign in_prim   = (bit_cnt <= P_LAST);
  assign in_sec    = sec_act && (bit_cnt >= S_FIRST) && (bit_cnt <= S_LAST);
  assign n_in_prim = (next_bit <= P_LAST);
  assign n_in_sec  = (next_bit >= S_FIRST) && (next_bit <= S_LAST);
  assign nsec_on   = (next_bit == S_FIRST) ? sec_pend : sec_act;

  assign rx_word   = {rx_q, sdi};
  assign prim_done = fall_tick && (bit_cnt == P_LAST);
  assign sec_done  = fall_tick && sec_act && (bit_cnt == S_LAST);
  assign req       = mode_wide ? ctl_req : rx_word[0];
  assign wr_en     = sec_done && !rx_word[WORD_W-1];

  sport_regfile #(
    .REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MODE_REG(MODE_REG), .MODE_BIT(MODE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(rx_word[DATA_W+ADDR_W-1:DATA_W]), .wr_data(rx_word[DATA_W-1:0]),
    .rd_addr(rx_q[ADDR_W-1:0]), .rd_data(rd_data), .mode_wide(mode_wide)
  );

  assign prim_load = cap_full ? cap_q : '0;
  assign rd_load   = {rd_data, {(WORD_W-DATA_W){1'b0}}};
  assign cap_take  = cap_valid && !cap_full;

  // Receive side: sample on falling sclk inside active slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= '0;
      sec_pend <= 1'b0;
      sec_act  <= 1'b0;
    end else begin
      if (fall_tick && (in_prim || in_sec))
        rx_q <= rx_word[WORD_W-2:0];
      if (prim_done)
        sec_pend <= req;
      else if (rise_tick && next_bit == S_FIRST)
        sec_pend <= 1'b0;
      if (rise_tick && next_bit == S_FIRST)
        sec_act <= sec_pend;
      else if (rise_tick && next_bit == S_LAST + 1'b1)
        sec_act <= 1'b0;
    end
  end

  // Transmit side: update on rising sclk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      sdo_q   <= 1'b0;
      fsync_q <= 1'b0;
    end else if (rise_tick) begin
      fsync_q <= (next_bit == F_LAST) || (next_bit == S_FIRST - 1'b1 && sec_pend);
      if (next_bit == '0) begin
        sdo_q <= prim_load[WORD_W-1];
        tx_q  <= prim_load << 1;
      end else if (n_in_sec && nsec_on && next_bit == S_RD && rx_q[RW_POS]) begin
        sdo_q <= rd_load[WORD_W-1];
        tx_q  <= rd_load << 1;
      end else if (n_in_prim || (n_in_sec && nsec_on)) begin
        sdo_q <= tx_q[WORD_W-1];
        tx_q  <= tx_q << 1;
      end else begin
        sdo_q <= 1'b0;
      end
    end
  end

  // Capture and playback streams
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= '0;
      cap_full <= 1'b0;
      play_q   <= '0;
      play_v_q <= 1'b0;
    end else begin
      if (cap_take) begin
        cap_q    <= cap_data;
        cap_full <= 1'b1;
      end else if (rise_tick && next_bit == '0) begin
        cap_full <= 1'b0;
      end
      if (prim_done) begin
        play_v_q <= 1'b1;
        play_q   <= mode_wide ? rx_word : {rx_word[WORD_W-1:1], 1'b0};
      end else if (play_v_q && play_ready) begin
        play_v_q <= 1'b0;
      end
    end
  end

  assign sdo        = sdo_q;
  assign fsync      = fsync_q;
  assign cap_ready  = !cap_full;
  assign play_data  = play_q;
  assign play_valid = play_v_q;
endmodule

// File: rtl/sport_checker.sv
module sport_checker #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic fsync,
  input logic sdo,
  input logic cap_valid,
  input logic cap_ready,
  input logic play_valid,
  input logic play_ready
);
  localparam int HALF = CLK_DIV / 2;

  logic [15:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= sclk ? hi_run + 1'b1 : '0;
  end

  assert_sclk_high_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi_run == 16'(HALF));

  assert_fsync_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $rose(sclk));

  assert_sdo_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $rose(sclk));

  assert_cap_full_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && cap_ready |=> !cap_ready);

  assert_play_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid && !play_ready |=> play_valid);
endmodule

bind codec_sport sport_checker #(.CLK_DIV(CLK_DIV)) u_sport_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .sdo(sdo),
  .cap_valid(cap_valid), .cap_ready(cap_ready),
  .play_valid(play_valid), .play_ready(play_ready)
);

// File: tb/tb_codec_sport.sv
`timescale 1ns/1ps
module tb_codec_sport;
  localparam int DIV   = 4;
  localparam int REG_N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sdi = 1'b0, ctl_req = 1'b0, cap_valid = 1'b0, play_ready = 1'b1;
  logic [15:0] cap_data = '0;
  logic sclk, fsync, sdo, cap_ready, play_valid;
  logic [15:0] play_data;

  codec_sport #(.CLK_DIV(DIV), .REG_COUNT(REG_N)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .sdo(sdo), .sdi(sdi),
    .ctl_req(ctl_req), .cap_data(cap_data), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .play_data(play_data), .play_valid(play_valid),
    .play_ready(play_ready)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int play_cnt = 0;
  logic [15:0] last_play = '0;
  logic [7:0] model [REG_N];
  logic wide = 1'b0;
  logic [15:0] cur_cap = '0;

  always @(negedge clk)
    if (play_valid && play_ready) begin
      last_play = play_data;
      play_cnt++;
    end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 29 + 6) & 8'hFE;
  endfunction

  task automatic run_frame(input logic [15:0] tx, input logic hw, input logic [15:0] ctl,
                           input logic push, input logic [15:0] ncap, input logic rdy,
                           input logic chk_play, input string tag);
    logic exp_sec;
    logic [15:0] got_p, got_s, exp_s, exp_play;
    int fs_bad, idle_bad, p0;
    int addr;
    got_p = '0; got_s = '0; fs_bad = 0; idle_bad = 0;
    exp_sec  = wide ? hw : tx[0];
    addr     = int'(ctl[12:8]);
    exp_s    = (exp_sec && ctl[15]) ? {8'h00, (addr < REG_N) ? model[addr] : 8'h00} : 16'h0000;
    exp_play = wide ? tx : {tx[15:1], 1'b0};
    p0 = play_cnt;
    for (int p = 0; p < 256; p++) begin
      @(posedge sclk); #1;
      ctl_req = hw;
      if (p < 16)                  sdi = tx[15 - p];
      else if (p >= 128 && p < 144) sdi = ctl[143 - p];
      else                         sdi = p[0];
      if (p == 50) play_ready = rdy;
      @(negedge sclk);
      if (p < 16)                  got_p = {got_p[14:0], sdo};
      else if (p >= 128 && p < 144) got_s = {got_s[14:0], sdo};
      else if (sdo !== 1'b0)       idle_bad++;
      if (fsync !== ((p == 255) || (p == 127 && exp_sec))) fs_bad++;
      if (p == 100 && push) begin
        chk(cap_ready === 1'b1, {"R4 ready before push ", tag}, 16'(cap_ready), 16'h1);
        @(negedge clk); cap_data = ncap; cap_valid = 1'b1;
        @(posedge clk); #1; cap_valid = 1'b0;
        chk(cap_ready === 1'b0, {"R4 ready after push ", tag}, 16'(cap_ready), 16'h0);
      end
    end
    chk(got_p === cur_cap, {"R3 R4 primary sdo ", tag}, got_p, cur_cap);
    chk(fs_bad == 0, {"R2 R8 fsync pattern ", tag}, 16'(fs_bad), 16'h0);
    chk(idle_bad == 0, {"R3 idle sdo ", tag}, 16'(idle_bad), 16'h0);
    chk(got_s === exp_s, {"R8 R11 control sdo ", tag}, got_s, exp_s);
    if (chk_play) begin
      chk(play_cnt == p0 + 1, {"R5 one play word ", tag}, 16'(play_cnt - p0), 16'h1);
      chk(last_play === exp_play, {wide ? "R7 play data " : "R6 play data ", tag}, last_play, exp_play);
    end
    if (exp_sec && !ctl[15] && addr < REG_N) model[addr] = ctl[7:0];
    wide = model[1][0];
    cur_cap = push ? ncap : 16'h0000;
  endtask

  initial begin : watchdog
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    longint t0, t1, t2;
    int pc;
    for (int i = 0; i < REG_N; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    chk(sclk === 1'b0 && fsync === 1'b0 && sdo === 1'b0, "R2 R3 reset outputs", {13'b0, sclk, fsync, sdo}, 16'h0);
    chk(cap_ready === 1'b1 && play_valid === 1'b0, "R4 R5 reset stream", {14'b0, cap_ready, play_valid}, 16'h2);
    @(negedge clk); rst_n = 1'b1;

    // R1: bit clock high time and period
    @(posedge sclk); t0 = $time;
    @(negedge sclk); t1 = $time;
    @(posedge sclk); t2 = $time;
    chk((t1 - t0) == (DIV / 2) * 5, "R1 sclk high time", 16'(t1 - t0), 16'((DIV / 2) * 5));
    chk((t2 - t0) == DIV * 5, "R1 sclk period", 16'(t2 - t0), 16'(DIV * 5));

    do @(negedge sclk); while (fsync !== 1'b1);

    // R6 R8: narrow, no request; control-slot write must be ignored
    run_frame(16'h1234, 1'b0, {1'b0, 2'b00, 5'd2, 8'h77}, 1'b1, 16'hA5C3, 1'b1, 1'b1, "narrow no-req");
    // R6 R10: D0=1 opens slot, write addr 3
    run_frame(16'hBEEF, 1'b0, {1'b0, 2'b11, 5'd3, 8'h5A}, 1'b1, 16'h0F0F, 1'b1, 1'b1, "narrow write");
    // R11: read back addr 3, read untouched addr 2
    run_frame(16'h8001, 1'b0, {1'b1, 2'b00, 5'd3, 8'hFF}, 1'b0, 16'h0000, 1'b1, 1'b1, "read a3");
    run_frame(16'h0003, 1'b0, {1'b1, 2'b00, 5'd2, 8'h00}, 1'b1, 16'h7E81, 1'b1, 1'b1, "read a2");

    // R9 R10: write sweep over all 32 addresses
    for (int a = 0; a < 32; a++)
      run_frame(16'((a * 2741) | 1), 1'b0, {1'b0, 2'(a), 5'(a), pat(a)}, 1'b1, 16'(a * 977 + 5),
                1'b1, 1'b1, "R10 write sweep");
    // R11: read sweep; addresses >= REG_N read zero
    for (int a = 0; a < 32; a++)
      run_frame(16'((a * 613) | 1), 1'b0, {1'b1, 2'b00, 5'(a), 8'hC3}, 1'b1, 16'(a * 311 + 9),
                1'b1, 1'b1, "R11 read sweep");

    // R6: hardware flag ignored in narrow mode
    run_frame(16'h4444, 1'b1, {1'b0, 2'b00, 5'd4, 8'h11}, 1'b0, 16'h0, 1'b1, 1'b1, "R6 hw ignored");
    run_frame(16'h0001, 1'b0, {1'b1, 2'b00, 5'd4, 8'h00}, 1'b0, 16'h0, 1'b1, 1'b1, "R6 a4 kept");

    // R7: switch to wide mode through register 1 bit 0
    run_frame(16'h0001, 1'b0, {1'b0, 2'b00, 5'd1, 8'h81}, 1'b0, 16'h0, 1'b1, 1'b1, "R7 set wide");
    chk(wide === 1'b1, "R7 model wide", 16'(wide), 16'h1);
    run_frame(16'hF00F, 1'b0, {1'b0, 2'b00, 5'd5, 8'hEE}, 1'b1, 16'h3C3C, 1'b1, 1'b1, "R7 D0 ignored");
    run_frame(16'h2222, 1'b1, {1'b1, 2'b00, 5'd5, 8'h00}, 1'b0, 16'h0, 1'b1, 1'b1, "R7 hw read a5");

    // R5: back-pressure and overwrite
    run_frame(16'h1357, 1'b0, 16'h0000, 1'b0, 16'h0, 1'b0, 1'b1, "R5 pre");
    pc = play_cnt;
    run_frame(16'hAAAA, 1'b0, 16'h0000, 1'b0, 16'h0, 1'b0, 1'b0, "R5 held");
    chk(play_valid === 1'b1 && play_cnt == pc, "R5 held valid", 16'(play_cnt - pc), 16'h0);
    chk(play_data === 16'hAAAA, "R5 held data", play_data, 16'hAAAA);
    run_frame(16'h5555, 1'b0, 16'h0000, 1'b0, 16'h0, 1'b1, 1'b0, "R5 replace");
    chk(play_cnt == pc + 1, "R5 one transfer after replace", 16'(play_cnt - pc), 16'h1);
    chk(last_play === 16'h5555, "R5 newer word delivered", last_play, 16'h5555);

    // R7 R6: back to narrow via hardware flag, then D0 read of reg 1
    run_frame(16'h0000, 1'b1, {1'b0, 2'b00, 5'd1, 8'h00}, 1'b0, 16'h0, 1'b1, 1'b1, "R7 clear wide");
    run_frame(16'h6661, 1'b0, {1'b1, 2'b00, 5'd1, 8'h00}, 1'b0, 16'h0, 1'b1, 1'b1, "R6 narrow again");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule